// File: doc/BRIEF.md
# Digital Ramp Converter Controller

This block sequences an analog-to-digital conversion that is built from an external DAC, a single comparator and a sample-and-hold. When a request arrives while the block is idle, it raises the hold command so the analog input is frozen. It then clears its code register, which drives the DAC directly, and advances that code by one on every clock. It stops when the comparator reports that the DAC output is above the held input.

The code present in the cycle where the comparator goes high becomes the result, and the done flag rises. If the code reaches all ones and the comparator is still low, the conversion stops with the full-scale code and flags overrange. The conversion time depends on the input: up to 2^W counting cycles, which is 1024 for the default width of 10. The block reports how many counting cycles the last conversion used. One cycle after done, it drops the hold command and becomes ready again.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After synchronous reset, hold, busy, done and overrange are 0, and dac_code, result and conv_cycles are 0.
- R2: A request seen at a rising edge while busy is 0 is accepted. After that edge, hold and busy are 1, done and overrange are 0, and dac_code is 0.
- R3: While counting, a cycle in which cmp_hi is 0 and dac_code is not all ones raises dac_code by exactly one at the next edge.
- R4: A counting cycle in which cmp_hi is 1 ends the conversion. After that edge, done is 1, overrange is 0 and result equals the dac_code of that cycle. With a comparator that is high when dac_code is greater than an integer input V, the result is V+1.
- R5: A counting cycle in which dac_code is all ones and cmp_hi is 0 ends the conversion. After that edge, result is all ones and overrange is 1. If cmp_hi is 1 in that cycle, R4 applies and overrange stays 0.
- R6: At the end of a conversion, conv_cycles takes the number of counting cycles used, which is the final dac_code plus one (up to 2^W).
- R7: Hold stays 1 from acceptance through the edge at which done rises. It falls, together with busy, exactly one edge later, so the input sample stays frozen for the whole count.
- R8: A request while busy is 1 is ignored. The count is not restarted, and done, result and overrange are unaffected.
- R9: Done and overrange stay at their values until the next accepted request clears them. Result and conv_cycles stay until the next conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Conversion request, sampled at each rising edge |
| cmp_hi | input | 1 | Comparator: 1 when the DAC output exceeds the held input |
| dac_code | output | W | Ramp code that drives the external DAC |
| hold | output | 1 | Hold command to the sample-and-hold |
| busy | output | 1 | Conversion or release cycle in progress |
| done | output | 1 | Last conversion finished |
| result | output | W | Converted code |
| overrange | output | 1 | Last conversion reached full scale without a comparator trip |
| conv_cycles | output | W+1 | Counting cycles used by the last conversion |

## Verification
The assertions assume that cmp_hi is a settled function of the current dac_code and the held input. They also assume that cmp_hi never drops back once the ramp has passed the input. The bench meets this by modelling the sample-and-hold as a register that loads only while hold is low. Its comparator is a pure combinational compare of dac_code against that register, so the trip point is monotonic. Requests are driven on falling edges only, and stray requests during a conversion test the ignore rule without changing the analog model.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_REL  = 2'd2
  } ramp_state_t;
endpackage

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] code,
  output logic         full,
  output logic [W:0]   steps
);
  localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      steps <= '0;
    end else if (clr) begin
      code  <= '0;
      steps <= {{W{1'b0}}, 1'b1};
    end else if (inc) begin
      code  <= code + 1'b1;
      steps <= steps + 1'b1;
    end
  end

  assign full = (code == CODE_MAX);

  // R3: every increment request moves the ramp by exactly one code
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (code == $past(code) + 1'b1));

  // R6: step count always leads the code by one once a conversion has begun
  a_r6_steps_track: assert property (@(posedge clk) disable iff (rst)
    clr |=> (steps == {1'b0, code} + 1'b1));
endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_adc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        cmp,
  input  logic        full,
  output logic        accept,
  output logic        inc,
  output logic        finish,
  output logic        release_now,
  output ramp_state_t state
);
  ramp_state_t state_nx;

  always_comb begin
    accept      = 1'b0;
    inc         = 1'b0;
    finish      = 1'b0;
    release_now = 1'b0;
    state_nx    = state;
    case (state)
      ST_IDLE: if (req) begin
        accept   = 1'b1;
        state_nx = ST_RUN;
      end
      ST_RUN: begin
        if (cmp || full) begin
          finish   = 1'b1;
          state_nx = ST_REL;
        end else begin
          inc = 1'b1;
        end
      end
      ST_REL: begin
        release_now = 1'b1;
        state_nx    = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  // R7: a finished conversion always spends exactly one cycle releasing
  a_r7_release_follows: assert property (@(posedge clk) disable iff (rst)
    finish |=> (state == ST_REL));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_req,
  input  logic         cmp_hi,
  output logic [W-1:0] dac_code,
  output logic         hold,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         overrange,
  output logic [W:0]   conv_cycles
);
  logic        accept, inc, finish, release_now, full;
  logic [W:0]  steps;
  ramp_state_t state;

  ramp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req(conv_req), .cmp(cmp_hi), .full(full),
    .accept(accept), .inc(inc), .finish(finish),
    .release_now(release_now), .state(state)
  );

  ramp_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .clr(accept), .inc(inc),
    .code(dac_code), .full(full), .steps(steps)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold        <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      result      <= '0;
      overrange   <= 1'b0;
      conv_cycles <= '0;
    end else begin
      if (accept) begin
        hold      <= 1'b1;
        busy      <= 1'b1;
        done      <= 1'b0;
        overrange <= 1'b0;
      end
      if (finish) begin
        done        <= 1'b1;
        result      <= dac_code;
        overrange   <= !cmp_hi;
        conv_cycles <= steps;
      end
      if (release_now) begin
        hold <= 1'b0;
        busy <= 1'b0;
      end
    end
  end

  // R2: acceptance starts a fresh ramp with the sample frozen
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && conv_req) |=> (hold && busy && !done && dac_code == '0));

  // R7: the input is held for every counting cycle
  a_r7_hold_in_run: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> hold);

  // R5: overrange only ever reports the full-scale code
  a_r5_ovr_full: assert property (@(posedge clk) disable iff (rst)
    overrange |-> (result == {W{1'b1}}));

  // R8/R9: outside acceptance, a raised done keeps itself and the result
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && busy) |=> (done && $stable(result)));
endmodule

// File: tb/ramp_adc_ctrl_tb_top.sv
module ramp_adc_ctrl_tb_top;
  localparam int W = 10;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         conv_req;
  logic         cmp_hi;
  logic [W-1:0] dac_code;
  logic         hold, busy, done, overrange;
  logic [W-1:0] result;
  logic [W:0]   conv_cycles;

  int errors = 0;
  int checks = 0;
  int live_in = 0;
  int held_in = 0;

  always #2 clk = ~clk;

  ramp_adc_ctrl #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .conv_req(conv_req), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .hold(hold), .busy(busy), .done(done),
    .result(result), .overrange(overrange), .conv_cycles(conv_cycles)
  );

  // behavioural sample-and-hold and comparator
  always_ff @(posedge clk) if (!hold) held_in <= live_in;
  assign cmp_hi = (int'(dac_code) > held_in);

  // vectors: input, expected result, expected cycles, expected overrange
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{0,    1,    2,    0},
    '{5,    6,    7,    0},
    '{300,  301,  302,  0},
    '{511,  512,  513,  0},
    '{1022, 1023, 1024, 0},
    '{1023, 1023, 1024, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one conversion; optional stray request and input change mid-ramp
  task automatic convert(input int vin, input int eres, input int ecyc,
                         input int eovr, input bit disturb);
    int n;
    live_in = vin;
    @(negedge clk); conv_req = 1'b1;
    @(negedge clk); conv_req = 1'b0;
    chk("R2 hold", int'(hold), 1);
    chk("R2 busy", int'(busy), 1);
    chk("R2 done", int'(done), 0);
    chk("R2 code", int'(dac_code), 0);
    n = 0;
    while (!done && n < 3000) begin
      if (int'(dac_code) != n) chk("R3 ramp", int'(dac_code), n);
      if (!hold) chk("R7 hold in run", int'(hold), 1);
      if (disturb && n == 2) begin
        conv_req = 1'b1;
        live_in  = 0;
      end else begin
        conv_req = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    conv_req = 1'b0;
    chk("R4 done", int'(done), 1);
    chk("R4 R5 result", int'(result), eres);
    chk("R5 overrange", int'(overrange), eovr);
    chk("R6 cycles", int'(conv_cycles), ecyc);
    chk("R6 latency", n, ecyc);
    chk("R7 hold at done", int'(hold), 1);
    conv_req = 1'b1;            // request during release cycle: ignored (R8)
    @(negedge clk); conv_req = 1'b0;
    chk("R7 hold released", int'(hold), 0);
    chk("R7 busy released", int'(busy), 0);
    @(negedge clk);
    chk("R8 not restarted", int'(busy), 0);
    chk("R9 done kept", int'(done), 1);
    chk("R9 result kept", int'(result), eres);
    chk("R9 ovr kept", int'(overrange), eovr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    conv_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 hold", int'(hold), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ovr", int'(overrange), 0);
    chk("R1 code", int'(dac_code), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 cycles", int'(conv_cycles), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      convert(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b0);

    // R8 stray request mid-ramp plus live input change; held value rules (R7)
    convert(40, 41, 42, 0, 1'b1);

    // R9 done cleared only on acceptance, overrange cleared too
    convert(FULL, FULL, FULL + 1, 1, 1'b0);
    live_in = 3;
    @(negedge clk); conv_req = 1'b1;
    @(negedge clk); conv_req = 1'b0;
    chk("R9 done cleared", int'(done), 0);
    chk("R9 ovr cleared", int'(overrange), 0);
    chk("R9 result until end", int'(result), FULL);
    repeat (10) @(negedge clk);
    chk("R4 after ovr", int'(result), 4);

    // R1 reset mid-conversion
    @(negedge clk); conv_req = 1'b1;
    @(negedge clk); conv_req = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 midrun busy", int'(busy), 0);
    chk("R1 midrun hold", int'(hold), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule